// File: doc/BRIEF.md
# Pipelined Burst Static Memory Core

This block is a clocked word memory built from four byte lanes with a registered read path. Each clock edge is one access. The access either loads a fresh address from the address port or continues the current four-word burst. A load also decides, from three chip-enable inputs, whether the device is selected. That decision then holds for every continue cycle until the next load. A selected access writes when a write enable is active and reads otherwise.

Read data leaves a lane register one edge after the address was taken. The output-drive signal is gated combinationally by an active-low output enable. That gate is held off for the first read that follows a deselected edge. The burst order within an aligned group of four words is linear or interleaved, as chosen by a static mode input. The memory depth is set by a parameter. A full-size part uses an address width of 16. The default width is kept small so that the core elaborates quickly.

Top module: `sbs_core`

## Requirements
- R1: On a load edge the device becomes selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination deselects it.
- R2: Chip enables are ignored on edges without a load. Continue edges keep the selection decided at the last load, whether that was selected or deselected.
- R3: A load happens when `adsp_n`=0 with `ce1_n`=0, or when `adsc_n`=0. With `adsp_n`=0, `ce1_n`=1 and `adsc_n`=1 there is no load, and the current burst address is reused. A load edge accesses `addr_i` itself.
- R4: A selected edge with `gw_n`=0 writes all four lanes of `wdata_i`, whatever `bwe_n` and `bw_n` are.
- R5: With `gw_n`=1 and `bwe_n`=0, lane i (bits 8i+7..8i) is written only where `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1 the selected edge is a read and nothing is written.
- R6: A read at edge N presents the addressed word on `rdata_o` after edge N. `drive_o` is then 1 while `oe_n`=0.
- R7: `drive_o` follows `oe_n` combinationally between clock edges, and is never 1 while `oe_n`=1.
- R8: For a read edge whose preceding edge was deselected, or for the first read after reset, `drive_o` stays 0 for that result whatever `oe_n` is.
- R9: A deselected edge writes nothing, and `drive_o` is 0 after it.
- R10: With `burst_linear`=1, continue edges with `adv_n`=0 step the low two address bits as start+k (mod 4). The upper bits stay fixed. `adv_n`=1 repeats the current address.
- R11: With `burst_linear`=0 the k-th advanced address in the group uses low bits start XOR k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address taken on a load edge |
| adsp_n | input | 1 | Processor-side load strobe, active low, gated by `ce1_n` |
| adsc_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance on continue edges, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Write of all lanes, active low |
| bwe_n | input | 1 | Lane-write qualifier, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| drive_o | output | 1 | Output driver enable for `rdata_o` |

## Verification
The hardest situation to reach is a continue edge that meets conflicting chip-enable or strobe inputs. Examples are a selected pattern on the enables during a deselected burst, or a processor strobe while `ce1_n` is high. These cases only count if the held selection and the burst address, both invisible at the ports, are shown not to move. The stimulus sets up a load, drives such edges with deliberately misleading enables, and then reads back. Lost or extra writes and the repeated address show up in the returned data. The output-enable mask is reached by putting one deselected load immediately in front of a read while `oe_n` stays low.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic { ORDER_INTERLEAVED = 1'b0, ORDER_LINEAR = 1'b1 } burst_order_e;

  // low address bits of the step-th access of a four-word group
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input burst_order_e order);
    logic [1:0] r;
    if (order == ORDER_LINEAR) r = start + step;
    else                       r = start ^ step;
    return r;
  endfunction

  function automatic logic chip_on(input logic ce1_n, input logic ce2, input logic ce3_n);
    return !ce1_n && ce2 && !ce3_n;
  endfunction

  function automatic logic load_strobe(input logic adsp_n, input logic adsc_n,
                                       input logic ce1_n);
    return (!adsp_n && !ce1_n) || !adsc_n;
  endfunction
endpackage

// File: rtl/sbs_seq.sv
module sbs_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv_n,
  input  logic              burst_linear,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              adv_evt
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q;
  logic [1:0]      start_q;
  logic [1:0]      step_q;
  logic [1:0]      step_use;
  burst_order_e    order;

  assign order    = burst_order_e'(burst_linear);
  assign adv_evt  = !load && !adv_n;
  assign step_use = adv_evt ? step_q + 2'd1 : step_q;

  always_comb begin
    if (load) acc_addr = addr_i;
    else      acc_addr = {base_q, burst_offset(start_q, step_use, order)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      step_q  <= '0;
    end else if (load) begin
      base_q  <= addr_i[ADDR_W-1:2];
      start_q <= addr_i[1:0];
      step_q  <= '0;
    end else if (adv_evt) begin
      step_q  <= step_use;
    end
  end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int NLANE = LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NLANE-1:0] bw_n,
  input  logic             oe_n,
  output logic [NLANE-1:0] lane_we,
  output logic             rd_en,
  output logic             sel_now,
  output logic             sel_q,
  output logic             prev_desel_q,
  output logic             drive_o
);
  logic rd_valid_q;
  logic mask_q;

  assign sel_now = load ? chip_on(ce1_n, ce2, ce3_n) : sel_q;
  assign rd_en   = sel_now && gw_n && bwe_n;

  for (genvar g = 0; g < NLANE; g++) begin : g_we
    assign lane_we[g] = sel_now && (!gw_n || (!bwe_n && !bw_n[g]));
  end

  assign drive_o = rd_valid_q && !mask_q && !oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q        <= 1'b0;
      prev_desel_q <= 1'b1;
      rd_valid_q   <= 1'b0;
      mask_q       <= 1'b0;
    end else begin
      sel_q        <= sel_now;
      prev_desel_q <= !sel_now;
      rd_valid_q   <= rd_en;
      mask_q       <= rd_en && prev_desel_q;
    end
  end
endmodule

// File: rtl/sbs_lane.sv
module sbs_lane #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd_q <= mem[addr];
  end

  assign rd = rd_q;
endmodule

// File: rtl/sbs_core.sv
module sbs_core
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic              burst_linear,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              load;
  logic              adv_evt;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;
  logic              rd_en;
  logic              sel_now;
  logic              sel_q;
  logic              prev_desel_q;

  assign load = load_strobe(adsp_n, adsc_n, ce1_n);

  sbs_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .adv_n(adv_n),
    .burst_linear(burst_linear), .addr_i(addr_i),
    .acc_addr(acc_addr), .adv_evt(adv_evt)
  );

  sbs_ctrl #(.NLANE(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .lane_we(lane_we), .rd_en(rd_en), .sel_now(sel_now), .sel_q(sel_q),
    .prev_desel_q(prev_desel_q), .drive_o(drive_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sbs_lane #(.ADDR_W(ADDR_W), .DATA_W(LANE_W)) u_lane (
      .clk(clk), .we(lane_we[l]), .re(rd_en), .addr(acc_addr),
      .wd(wdata_i[l*LANE_W +: LANE_W]),
      .rd(rdata_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/sbs_core_chk.sv
module sbs_core_chk
  import sbs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             gw_n,
  input logic             drive_o,
  input logic             load,
  input logic             adv_evt,
  input logic             sel_now,
  input logic             sel_q,
  input logic             rd_en,
  input logic             prev_desel_q,
  input logic [LANES-1:0] lane_we
);
  p_gw_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && !gw_n) |-> (lane_we == '1));

  p_desel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_now) |-> (lane_we == '0 && !rd_en));

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (sel_q == $past(sel_q)));

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> !oe_n);

  p_mask_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && prev_desel_q) |=> !drive_o);

  p_drive_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> $past(rd_en));

  p_adv_not_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv_evt && load));
endmodule

bind sbs_core sbs_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .gw_n(gw_n), .drive_o(drive_o),
  .load(load), .adv_evt(adv_evt), .sel_now(sel_now), .sel_q(sel_q),
  .rd_en(rd_en), .prev_desel_q(prev_desel_q), .lane_we(lane_we)
);

// File: tb/test_sbs_core.sv
`timescale 1ns/100ps
module test_sbs_core;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] SEL = 3'b010;  // {ce1_n, ce2, ce3_n}

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1, burst_linear = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          drive_o;

  always #2 clk = ~clk;

  sbs_core #(.ADDR_W(AW)) i_sbs_core (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .burst_linear(burst_linear),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  typedef struct {
    logic        chk_data;
    logic [31:0] data;
    logic        drive;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_run = 0, n_fail = 0;
  bit          done = 0;
  logic [31:0] ref_mem [DEPTH];
  logic          m_sel = 1'b0, m_prev_desel = 1'b1;
  logic [AW-1:0] m_base = '0;
  int            m_step = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // position in the group, restated from R10/R11
  function automatic logic [AW-1:0] group_addr(input logic [AW-1:0] base, input int k, input logic lin);
    int s = int'(base[1:0]);
    int o;
    o = lin ? ((s + k) % 4) : (s ^ (k % 4));
    return (base & ~AW'(3)) | AW'(o);
  endfunction

  // ld: 0 none, 1 processor strobe, 2 controller strobe
  task automatic cyc(input int ld, input logic [2:0] ce, input logic adv, input logic gw,
                     input logic bwe, input logic [3:0] bw, input logic oe,
                     input logic [AW-1:0] a, input logic [31:0] wd, input string tag);
    logic          ld_hit, rd, sel;
    logic [AW-1:0] acc;
    exp_t          it;
    @(negedge clk);
    adsp_n = !(ld == 1); adsc_n = !(ld == 2);
    {ce1_n, ce2, ce3_n} = ce;
    adv_n = adv; gw_n = gw; bwe_n = bwe; bw_n = bw; oe_n = oe;
    addr_i = a; wdata_i = wd;
    ld_hit = (ld == 1 && !ce[2]) || (ld == 2);
    if (ld_hit) begin
      m_sel = (ce == SEL); m_base = a; m_step = 0; acc = a;
    end else begin
      if (!adv) m_step++;
      acc = group_addr(m_base, m_step, burst_linear);
    end
    sel = m_sel;
    rd  = sel && gw && bwe;
    it.chk_data = rd;
    it.data     = ref_mem[acc];
    it.drive    = rd && !oe && !m_prev_desel;
    it.tag      = tag;
    for (int l = 0; l < 4; l++)
      if (sel && (!gw || (!bwe && !bw[l]))) ref_mem[acc][l*8 +: 8] = wd[l*8 +: 8];
    m_prev_desel = !sel;
    @(posedge clk);
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    cyc(2, SEL, 1'b1, 1'b0, 1'b1, 4'hF, 1'b1, a, d, tag);
  endtask
  task automatic rdl(input int ld, input logic [AW-1:0] a, input string tag);
    cyc(ld, SEL, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, a, 32'h0, tag);
  endtask
  task automatic nxt(input logic adv, input string tag);
    cyc(0, 3'b111, adv, 1'b1, 1'b1, 4'hF, 1'b0, '0, 32'h0, tag);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check(drive_o === it.drive, {it.tag, " drive"}, {31'b0, drive_o}, {31'b0, it.drive});
      if (it.chk_data)
        check(rdata_o === it.data, {it.tag, " data"}, rdata_o, it.data);
    end
  end

  initial begin
    #(4 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    oe_n = 1'b0;
    #0.1;
    check(drive_o === 1'b0, "R9 reset drive", {31'b0, drive_o}, 32'd0);
    rst_n = 1'b1;

    // R4: all lanes despite lane selects
    cyc(2, SEL, 1'b1, 1'b0, 1'b1, 4'b0101, 1'b1, 10'h010, 32'h11223344, "R4");
    rdl(1, 10'h010, "R4 R6");
    // R5: lanes 0 and 2
    cyc(2, SEL, 1'b1, 1'b1, 1'b0, 4'b1010, 1'b1, 10'h010, 32'hA1B2C3D4, "R5");
    rdl(2, 10'h010, "R5 R6");
    cyc(2, SEL, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 10'h010, 32'hFFFFFFFF, "R5 no-write read");
    rdl(2, 10'h010, "R5");

    // R10 linear burst
    for (int i = 0; i < 4; i++) wr(AW'(32 + i), 32'h5000_0000 + i, "R10 fill");
    burst_linear = 1'b1;
    rdl(2, 10'h022, "R10 start");
    nxt(1'b0, "R10 step1"); nxt(1'b0, "R10 step2"); nxt(1'b0, "R10 step3");
    nxt(1'b1, "R10 hold");
    nxt(1'b0, "R10 wrap");
    // R11 interleaved burst
    burst_linear = 1'b0;
    rdl(1, 10'h021, "R11 start");
    nxt(1'b0, "R11 step1"); nxt(1'b0, "R11 step2"); nxt(1'b0, "R11 step3");
    // burst writes with continue edges
    cyc(2, SEL, 1'b1, 1'b0, 1'b1, 4'hF, 1'b1, 10'h02A, 32'hC0DE0000, "R11 bw0");
    cyc(0, 3'b111, 1'b0, 1'b0, 1'b1, 4'hF, 1'b1, '0, 32'hC0DE0001, "R11 bw1");
    cyc(0, 3'b111, 1'b0, 1'b0, 1'b1, 4'hF, 1'b1, '0, 32'hC0DE0002, "R11 bw2");
    rdl(2, 10'h02B, "R11 readback");
    rdl(2, 10'h028, "R11 readback");

    // R1 decode
    wr(10'h030, 32'h55555555, "R1");
    cyc(2, 3'b000, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 10'h030, 32'hAAAA0001, "R1 ce2 low");
    cyc(2, 3'b011, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 10'h030, 32'hAAAA0002, "R1 ce3 high");
    cyc(2, 3'b110, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 10'h030, 32'hAAAA0003, "R1 ce1 high");
    cyc(2, 3'b000, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 10'h030, 32'h0, "R1 R9 desel read");
    rdl(2, 10'h030, "R1 R8 masked");
    nxt(1'b1, "R1 R8 unmasked");

    // R2 held deselection vs selected-looking enables
    cyc(2, 3'b000, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 10'h030, 32'h0, "R2 desel load");
    cyc(0, SEL, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, '0, 32'hDEADBEEF, "R2 R9 no write");
    cyc(0, SEL, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, '0, 32'h0, "R2 R9 no read");
    rdl(2, 10'h030, "R2 R8");
    nxt(1'b1, "R2 readback");
    // R2 held selection across junk enables
    nxt(1'b1, "R2 held sel");

    // R3 processor strobe ignored with ce1_n high
    rdl(2, 10'h010, "R3 base");
    cyc(1, 3'b110, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 10'h020, 32'h0, "R3 ignored strobe");
    cyc(1, SEL, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 10'h020, 32'h0, "R3 taken strobe");

    // R7 asynchronous output enable
    rdl(2, 10'h020, "R7 setup");
    #1.5;
    oe_n = 1'b1; #0.1;
    check(drive_o === 1'b0, "R7 oe high", {31'b0, drive_o}, 32'd0);
    oe_n = 1'b0; #0.1;
    check(drive_o === 1'b1, "R7 oe low", {31'b0, drive_o}, 32'd1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule